// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block drives the frame clock and the bit clock of an audio serial port in master mode. Both clocks come from a single master clock. A speed field picks a prescale factor of 4, 2 or 1. The prescaled clock runs an internal frame counter, whose length is set by a ratio field. The ratio field also sets how many bit-clock periods fall in one frame. Some ratio settings are not powers of two, for example 62 bit clocks in 125 internal cycles. For these, the bit-clock edges come from a phase accumulator instead of a plain divider, so the bit clock never drifts against the frame.

The block also gives a one-cycle strobe at the start of every frame. New speed and ratio settings take effect only at a frame boundary, so every frame is complete and follows one configuration. When the master-mode select is low, the port is in slave mode: all three outputs stay low and the counters stay idle. When the auto-detect enable is set, the speed field is ignored and the prescale factor is 2.

Top module: `aud_clkgen`

## Requirements
- R1: The speed field (00, 01, 10, 11) sets the prescale to 4, 2, 1 and 1 master cycles per internal cycle. With ratio 00, a frame therefore lasts 512, 256, 128 and 128 master cycles.
- R2: The ratio field (00, 01, 10, 11) sets the internal cycles per frame to 128, 125, 132 and 136. A frame lasts the prescale times that count, in master cycles.
- R3: The bit clock has exactly 64, 62, 66 or 68 rising edges per frame, for ratio 00, 01, 10 and 11.
- R4: Within one frame, the longest and the shortest bit-clock period differ by no more than one internal cycle (the prescale, in master cycles).
- R5: The frame clock is high for the first floor(N/2) internal cycles of an N-cycle frame and low for the rest. For an odd N, the extra cycle goes to the low phase.
- R6: The frame-start strobe is high for exactly one master cycle per frame. In that cycle the frame clock has just gone high and the bit clock is low.
- R7: While the auto-detect enable is 1, the speed field has no effect and the prescale is 2.
- R8: While the master-mode select is 0, the frame clock, the bit clock and the strobe are all held low. The first master cycle after the select returns to 1 starts a new frame.
- R9: A change of the speed or ratio field during a frame leaves that frame's length unchanged. The new setting applies from the next frame.
- R10: While the synchronous reset is high, all outputs are low. The first clock edge with reset low starts a frame: the strobe and the frame clock go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| master_en | input | 1 | 1 = master mode (clocks generated), 0 = slave mode |
| auto_en | input | 1 | Auto-detect enable; forces prescale 2 and ignores speed_sel |
| speed_sel | input | 2 | Speed mode: 00 double, 01 single, 10 half, 11 quarter |
| ratio_sel | input | 2 | Internal ratio: 00 128/64, 01 125/62, 10 132/66, 11 136/68 |
| lrck_o | output | 1 | Frame clock |
| sclk_o | output | 1 | Bit clock |
| frame_start_o | output | 1 | One-cycle pulse at the first cycle of each frame |

## Verification
The assertions assume that every frame lasts well over two master cycles, which holds for every field encoding, so that a strobe can never be followed by a second one. They also assume that the configuration inputs are changed between clock edges and never at an edge. The stimulus changes fields only on the falling edge, and it also changes them in the middle of a frame, so that the check that the setting is held at frame boundaries is actually exercised. The mode select and the reset are also toggled only on the falling edge. Periods of slave mode are long enough for the quiet-output property to be checked over many cycles.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;

   typedef enum logic [1:0] {
      SPD_DOUBLE  = 2'b00,
      SPD_SINGLE  = 2'b01,
      SPD_HALF    = 2'b10,
      SPD_QUARTER = 2'b11
   } speed_e;

   // master cycles per internal cycle
   function automatic int speed_div(input logic auto_on, input logic [1:0] spd);
      speed_e s;
      s = speed_e'(spd);
      if (auto_on) return 2;
      case (s)
         SPD_DOUBLE: return 4;
         SPD_SINGLE: return 2;
         default:    return 1;
      endcase
   endfunction

   // internal cycles per frame
   function automatic int frame_cycles(input logic [1:0] rat);
      case (rat)
         2'b00:   return 128;
         2'b01:   return 125;
         2'b10:   return 132;
         default: return 136;
      endcase
   endfunction

   // bit-clock periods per frame
   function automatic int bit_periods(input logic [1:0] rat);
      case (rat)
         2'b00:   return 64;
         2'b01:   return 62;
         2'b10:   return 66;
         default: return 68;
      endcase
   endfunction

endpackage

// File: rtl/aud_cg_prescale.sv
module aud_cg_prescale #(
   parameter int PRE_W   = 3,
   parameter int MAX_PRE = 4
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             run,
   input  logic [PRE_W-1:0] div,
   output logic             tick
);

   generate
      if (MAX_PRE == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         logic [PRE_W-1:0] cnt_q;
         logic             at_end;

         assign at_end = (cnt_q == div - 1'b1);
         assign tick   = run && at_end;

         always_ff @(posedge clk) begin
            if (clr || !run) begin
               cnt_q <= '0;
            end else if (at_end) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/aud_cg_frame.sv
module aud_cg_frame #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             tick,
   input  logic [LEN_W-1:0] flen,
   output logic             run,
   output logic             lrck,
   output logic             strobe,
   output logic             boundary
);

   logic [LEN_W-1:0] pos_q;
   logic [LEN_W-1:0] pos_nx;
   logic             last;

   assign last     = (pos_q == flen - 1'b1);
   assign pos_nx   = last ? '0 : pos_q + 1'b1;
   assign boundary = !run || (tick && last);

   always_ff @(posedge clk) begin
      if (clr) begin
         run    <= 1'b0;
         pos_q  <= '0;
         lrck   <= 1'b0;
         strobe <= 1'b0;
      end else if (!run) begin
         run    <= 1'b1;
         pos_q  <= '0;
         lrck   <= 1'b1;
         strobe <= 1'b1;
      end else begin
         strobe <= tick && last;
         if (tick) begin
            pos_q <= pos_nx;
            lrck  <= (pos_nx < (flen >> 1));
         end
      end
   end

endmodule

// File: rtl/aud_cg_bitclk.sv
module aud_cg_bitclk #(
   parameter int LEN_W  = 8,
   parameter int BITS_W = 7
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              tick,
   input  logic [LEN_W-1:0]  flen,
   input  logic [BITS_W-1:0] nbits,
   output logic              sclk
);

   localparam int ACC_W = LEN_W + 1;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] step;
   logic [ACC_W-1:0] sum;
   logic [ACC_W-1:0] limit;
   logic             wrap;

   // two edges per bit-clock period
   assign step  = ACC_W'({nbits, 1'b0});
   assign limit = ACC_W'(flen);
   assign sum   = acc_q + step;
   assign wrap  = (sum >= limit);

   always_ff @(posedge clk) begin
      if (clr) begin
         acc_q <= '0;
         sclk  <= 1'b0;
      end else if (tick) begin
         acc_q <= wrap ? sum - limit : sum;
         if (wrap) sclk <= !sclk;
      end
   end

endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
   import aud_clkgen_pkg::*;
#(
   parameter int PRE_W   = 3,
   parameter int LEN_W   = 8,
   parameter int BITS_W  = 7,
   parameter int MAX_PRE = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       master_en,
   input  logic       auto_en,
   input  logic [1:0] speed_sel,
   input  logic [1:0] ratio_sel,
   output logic       lrck_o,
   output logic       sclk_o,
   output logic       frame_start_o
);

   generate
      if (LEN_W < 8) begin : g_bad_len
         $error("LEN_W must hold a frame count of 136");
      end
      if (BITS_W < 7) begin : g_bad_bits
         $error("BITS_W must hold a bit count of 68");
      end
      if (MAX_PRE >= (1 << PRE_W)) begin : g_bad_pre
         $error("PRE_W too narrow for MAX_PRE");
      end
   endgenerate

   logic              hold;
   logic              run;
   logic              tick;
   logic              frm_boundary;
   logic [PRE_W-1:0]  cfg_div;
   logic [LEN_W-1:0]  cfg_len;
   logic [BITS_W-1:0] cfg_bits;

   assign hold = rst || !master_en;

   // settings taken only while idle or on the last internal cycle of a frame
   always_ff @(posedge clk) begin
      if (hold || frm_boundary) begin
         cfg_div  <= PRE_W'(speed_div(auto_en, speed_sel));
         cfg_len  <= LEN_W'(frame_cycles(ratio_sel));
         cfg_bits <= BITS_W'(bit_periods(ratio_sel));
      end
   end

   aud_cg_prescale #(.PRE_W(PRE_W), .MAX_PRE(MAX_PRE)) u_pre (
      .clk  (clk),
      .clr  (hold),
      .run  (run),
      .div  (cfg_div),
      .tick (tick)
   );

   aud_cg_frame #(.LEN_W(LEN_W)) u_frm (
      .clk      (clk),
      .clr      (hold),
      .tick     (tick),
      .flen     (cfg_len),
      .run      (run),
      .lrck     (lrck_o),
      .strobe   (frame_start_o),
      .boundary (frm_boundary)
   );

   aud_cg_bitclk #(.LEN_W(LEN_W), .BITS_W(BITS_W)) u_bck (
      .clk   (clk),
      .clr   (hold),
      .tick  (tick),
      .flen  (cfg_len),
      .nbits (cfg_bits),
      .sclk  (sclk_o)
   );

endmodule

// File: rtl/aud_clkgen_chk.sv
module aud_clkgen_chk #(
   parameter int PRE_W = 3,
   parameter int LEN_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             master_en,
   input logic             lrck,
   input logic             sclk,
   input logic             strobe,
   input logic             boundary,
   input logic [LEN_W-1:0] cfg_len,
   input logic [PRE_W-1:0] cfg_div
);

   AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !master_en |=> (!lrck && !sclk && !strobe)); // R8

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe); // R6

   AST_LRCK_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
      $rose(lrck) |-> strobe); // R5

   AST_START_LEVELS: assert property (@(posedge clk) disable iff (rst)
      strobe |-> (lrck && !sclk)); // R6

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
      (master_en && !boundary) |=> ($stable(cfg_len) && $stable(cfg_div))); // R9

endmodule

bind aud_clkgen aud_clkgen_chk #(.PRE_W(PRE_W), .LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .master_en (master_en),
   .lrck      (lrck_o),
   .sclk      (sclk_o),
   .strobe    (frame_start_o),
   .boundary  (frm_boundary),
   .cfg_len   (cfg_len),
   .cfg_div   (cfg_div)
);

// File: tb/aud_clkgen_bench.sv
module aud_clkgen_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       master_en = 1'b1;
   logic       auto_en = 1'b0;
   logic [1:0] speed_sel = 2'b00;
   logic [1:0] ratio_sel = 2'b00;
   logic       lrck, sclk, fs;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   aud_clkgen u_aud_clkgen (
      .clk           (clk),
      .rst           (rst),
      .master_en     (master_en),
      .auto_en       (auto_en),
      .speed_sel     (speed_sel),
      .ratio_sel     (ratio_sel),
      .lrck_o        (lrck),
      .sclk_o        (sclk),
      .frame_start_o (fs)
   );

   // {auto, speed, ratio, frame master cycles, sclk rises, lrck high cycles, prescale}
   localparam int NV = 11;
   localparam int VEC [NV][7] = '{
      '{0, 0, 0, 512, 64, 256, 4},
      '{0, 1, 0, 256, 64, 128, 2},
      '{0, 2, 0, 128, 64,  64, 1},
      '{0, 3, 0, 128, 64,  64, 1},
      '{0, 2, 1, 125, 62,  62, 1},
      '{0, 2, 2, 132, 66,  66, 1},
      '{0, 2, 3, 136, 68,  68, 1},
      '{0, 0, 1, 500, 62, 248, 4},
      '{1, 0, 0, 256, 64, 128, 2},
      '{1, 3, 1, 250, 62, 124, 2},
      '{0, 1, 3, 272, 68, 136, 2}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_start();
      int g = 0;
      do begin
         @(negedge clk);
         g++;
      end while (!fs && g < 3000);
   endtask

   // called at a negedge where fs is high; returns at the next frame start
   task automatic measure(output int len, output int hi, output int rises,
                          output int pmin, output int pmax);
      int c = 0;
      int last = -1;
      logic prev;
      hi = lrck ? 1 : 0;
      rises = 0;
      pmin = 100000;
      pmax = 0;
      prev = sclk;
      forever begin
         @(negedge clk);
         c++;
         if (fs || c > 3000) break;
         if (lrck) hi++;
         if (sclk && !prev) begin
            rises++;
            if (last >= 0) begin
               if (c - last < pmin) pmin = c - last;
               if (c - last > pmax) pmax = c - last;
            end
            last = c;
         end
         prev = sclk;
      end
      len = c;
   endtask

   initial begin
      int len, hi, rises, pmin, pmax, c, noise;
      // R10: reset state
      repeat (4) @(negedge clk);
      chk("R10 lrck in reset", lrck, 0);
      chk("R10 sclk in reset", sclk, 0);
      chk("R10 strobe in reset", fs, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R10 strobe after release", fs, 1);
      chk("R10 lrck after release", lrck, 1);

      // vector table
      for (int i = 0; i < NV; i++) begin
         auto_en   = VEC[i][0][0];
         speed_sel = 2'(VEC[i][1]);
         ratio_sel = 2'(VEC[i][2]);
         wait_start();
         measure(len, hi, rises, pmin, pmax);
         chk($sformatf("R1 R2 R7 frame length vec%0d", i), len, VEC[i][3]);
         chk($sformatf("R3 sclk rises vec%0d", i), rises, VEC[i][4]);
         chk($sformatf("R5 lrck high vec%0d", i), hi, VEC[i][5]);
         chk($sformatf("R4 period spread within prescale vec%0d", i),
             (pmax - pmin <= VEC[i][6]) ? 1 : 0, 1);
      end

      // R9: mid-frame change keeps current frame
      auto_en = 1'b0; speed_sel = 2'b01; ratio_sel = 2'b00;
      wait_start();
      wait_start();
      c = 0;
      repeat (40) begin @(negedge clk); c++; end
      ratio_sel = 2'b11;
      speed_sel = 2'b00;
      do begin @(negedge clk); c++; end while (!fs && c < 3000);
      chk("R9 frame with mid change", c, 256);
      measure(len, hi, rises, pmin, pmax);
      chk("R9 following frame uses new setting", len, 544);

      // R7: speed changes ignored under auto-detect
      auto_en = 1'b1; speed_sel = 2'b10; ratio_sel = 2'b00;
      wait_start();
      measure(len, hi, rises, pmin, pmax);
      chk("R7 auto ignores speed 10", len, 256);

      // R8: slave mode silence and restart
      master_en = 1'b0;
      noise = 0;
      repeat (300) begin
         @(negedge clk);
         if (lrck || sclk || fs) noise++;
      end
      chk("R8 outputs quiet in slave mode", noise, 0);
      master_en = 1'b1;
      @(negedge clk);
      chk("R8 strobe on return to master", fs, 1);
      chk("R8 lrck on return to master", lrck, 1);

      // R10: reset during operation
      repeat (37) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R10 quiet after mid-run reset", (lrck || sclk || fs) ? 1 : 0, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R10 restart strobe", fs, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule